// File: doc/BRIEF.md
# Line Switch State Controller

This block is the digital control core of a four-pole solid-state line-card switch. It drives two break switches (A and B), which connect the line to the subscriber interface, and two ringing switches (A and B), which connect the ring generator. Three switch states are decoded: talk, ringing and all-off. The state follows a ring-select input and an active-low disable input. The disable input is also the means of commanding all-off.

Two inputs are asynchronous: the supply-good indication and the freeze input. Each passes through two synchronising flops. The supply indication is then qualified with separate rise and fall counts, which act as threshold hysteresis. While the supply is not good, every switch is forced open. After the supply comes up, a hold keeps the block in all-off until the freeze input has been seen low. A freeze input that is high later on freezes the accepted command. When the block leaves ringing, ringing switch B stays closed until a ring-current zero-crossing pulse arrives. If no pulse arrives, a timeout opens it instead. With direct ring-to-talk changes this gives make-before-break. Holding disable low across the change gives break-before-make.

The states are named OFF (2'b00), TALK (2'b01) and RING (2'b10). The transitions are named as follows. POWER_DROP goes from any state to OFF when the supply is not good or the hold is set. DISABLE goes from any state to OFF when disable is low. SELECT moves between TALK and RING following ring-select. RESUME leaves OFF for the commanded state. LEAVE_RING exits RING and arms the pending release of ringing switch B.

Top module: `line_switch_ctrl`

## Requirements
- R1: In TALK, both break switches are closed and both ringing switches are open. TALK is selected by ring_sel_i = 0 with disable_n_i = 1.
- R2: In RING, both ringing switches are closed and both break switches are open. RING is selected by ring_sel_i = 1 with disable_n_i = 1.
- R3: When disable_n_i is sampled low, the next cycle has both break switches and ringing switch A open. This holds even while the command is frozen. A ringing switch B that is already closed follows R8/R10.
- R4: While the qualified supply is not good, all four outputs are open and ring_sel_i and disable_n_i have no effect.
- R5: Supply-good changes its qualified value only after RISE_CNT consecutive synchronised high samples, or after FALL_CNT consecutive synchronised low samples. Shorter excursions have no effect.
- R6: After the supply becomes good, the block stays in OFF until the synchronised freeze input is low. If freeze is already low, it enters the commanded state without further action.
- R7: Once released, a high freeze input keeps the last accepted ring-select command. Driving it low again makes the block follow ring_sel_i.
- R8: On leaving RING, ringing switch A opens and the new state is applied in the same cycle. Ringing switch B stays closed until the cycle after a zero-cross pulse. A pulse sampled in the same cycle as the exit is not counted.
- R9: Break-before-make works as follows: disable is held low from RING while talk is selected, and a zero-cross pulse arrives. The break switches then close only in the cycle after disable returns high.
- R10: If no zero-cross pulse arrives, ringing switch B opens ZC_TMO cycles after the exit from RING.
- R11: Returning to RING while ringing switch B is pending cancels the pending release. A zero-cross pulse in RING has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sel_i | input | 1 | 1 selects ringing, 0 selects talk |
| disable_n_i | input | 1 | Active-low disable, forces switches open |
| freeze_i | input | 1 | Freeze input; high blocks command changes and holds all-off at power-up |
| supply_ok_i | input | 1 | Raw supply-good indication, asynchronous |
| zc_pulse_i | input | 1 | Single-cycle ring-current zero-crossing strobe |
| brk_a_en_o | output | 1 | Break switch A closed |
| brk_b_en_o | output | 1 | Break switch B closed |
| rng_a_en_o | output | 1 | Ringing switch A closed |
| rng_b_en_o | output | 1 | Ringing switch B closed (zero-cross released) |

## Verification
A zero-cross pulse can land in the same cycle that the state leaves RING. This is provoked by driving ring-select low and the strobe high in one vector. The check is that ringing switch B is still closed afterwards and opens only on the following pulse. A zero-cross strobe can also land while the block sits in RING, or while a return to RING cancels a pending release. In both cases the check is that ringing switch B stays closed.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_TALK = 2'b01,
        ST_RING = 2'b10
    } sw_state_e;
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lsw_supply_qual.sv
module lsw_supply_qual #(
    parameter int unsigned RISE_CNT = 16,
    parameter int unsigned FALL_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_s_i,
    output logic pwr_ok_o
);
    localparam int unsigned MAXC = (RISE_CNT > FALL_CNT) ? RISE_CNT : FALL_CNT;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = pwr_ok_o ? CW'(FALL_CNT - 1) : CW'(RISE_CNT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            pwr_ok_o <= 1'b0;
        end else if (sup_s_i == pwr_ok_o) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt      <= '0;
            pwr_ok_o <= ~pwr_ok_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lsw_ring_release.sv
module lsw_ring_release #(
    parameter int unsigned ZC_TMO = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill_i,
    input  logic leave_i,
    input  logic reenter_i,
    input  logic zc_i,
    output logic pend_o,
    output logic expire_o
);
    localparam int unsigned TW = $clog2(ZC_TMO + 1);

    logic [TW-1:0] timer;

    assign expire_o = pend_o && (timer == TW'(ZC_TMO - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            timer  <= '0;
        end else if (kill_i) begin
            pend_o <= 1'b0;
            timer  <= '0;
        end else if (leave_i) begin
            pend_o <= 1'b1;
            timer  <= '0;
        end else if (reenter_i) begin
            pend_o <= 1'b0;
            timer  <= '0;
        end else if (pend_o && (zc_i || expire_o)) begin
            pend_o <= 1'b0;
            timer  <= '0;
        end else if (pend_o) begin
            timer <= timer + 1'b1;
        end
    end
endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RISE_CNT    = 16,
    parameter int unsigned FALL_CNT    = 4,
    parameter int unsigned ZC_TMO      = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_sel_i,
    input  logic disable_n_i,
    input  logic freeze_i,
    input  logic supply_ok_i,
    input  logic zc_pulse_i,
    output logic brk_a_en_o,
    output logic brk_b_en_o,
    output logic rng_a_en_o,
    output logic rng_b_en_o
);
    logic      sup_s;
    logic      frz_s;
    logic      pwr_ok;
    logic      hold_q;
    logic      pend;
    logic      rel_expire;
    logic      leave;
    logic      reenter;
    logic      accept;
    sw_state_e st, nxt, live, cmd_q;

    lsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
        .clk(clk), .rst_n(rst_n), .d_i(supply_ok_i), .q_o(sup_s)
    );

    lsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_frz (
        .clk(clk), .rst_n(rst_n), .d_i(freeze_i), .q_o(frz_s)
    );

    lsw_supply_qual #(.RISE_CNT(RISE_CNT), .FALL_CNT(FALL_CNT)) u_qual (
        .clk(clk), .rst_n(rst_n), .sup_s_i(sup_s), .pwr_ok_o(pwr_ok)
    );

    // power-up hold and command capture
    assign live   = ring_sel_i ? ST_RING : ST_TALK;
    assign accept = pwr_ok && !hold_q && !frz_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            cmd_q  <= ST_OFF;
        end else if (!pwr_ok) begin
            hold_q <= 1'b1;
            cmd_q  <= ST_OFF;
        end else begin
            if (!frz_s) hold_q <= 1'b0;
            if (accept) cmd_q  <= live;
        end
    end

    // next-state selection
    always_comb begin
        if (!pwr_ok || hold_q) begin
            nxt = ST_OFF;                 // POWER_DROP
        end else if (!disable_n_i) begin
            nxt = ST_OFF;                 // DISABLE
        end else if (accept) begin
            nxt = live;                   // SELECT / RESUME
        end else begin
            nxt = cmd_q;                  // frozen command
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    assign leave   = (st == ST_RING) && (nxt != ST_RING);   // LEAVE_RING
    assign reenter = (nxt == ST_RING);

    lsw_ring_release #(.ZC_TMO(ZC_TMO)) u_rel (
        .clk(clk), .rst_n(rst_n), .kill_i(!pwr_ok), .leave_i(leave),
        .reenter_i(reenter), .zc_i(zc_pulse_i), .pend_o(pend),
        .expire_o(rel_expire)
    );

    // outputs
    always_comb begin
        brk_a_en_o = 1'b0;
        brk_b_en_o = 1'b0;
        rng_a_en_o = 1'b0;
        rng_b_en_o = pend;
        unique case (st)
            ST_OFF: ;
            ST_TALK: begin
                brk_a_en_o = 1'b1;
                brk_b_en_o = 1'b1;
            end
            ST_RING: begin
                rng_a_en_o = 1'b1;
                rng_b_en_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsw_chk.sv
module lsw_chk (
    input logic clk,
    input logic rst_n,
    input logic disable_n,
    input logic zc,
    input logic pwr_ok,
    input logic expire,
    input logic brk_a,
    input logic brk_b,
    input logic rng_a,
    input logic rng_b
);
    // R1
    brk_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_a == brk_b);

    // R2
    no_brk_ring_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_a && rng_a));

    // R2
    ring_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rng_a |-> rng_b);

    // R3
    disable_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disable_n |=> (!brk_a && !brk_b && !rng_a));

    // R4
    supply_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !(brk_a || brk_b || rng_a || rng_b));

    // R8
    ringb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rng_b) |-> ($past(zc) || $past(expire) || !$past(pwr_ok)));
endmodule

bind line_switch_ctrl lsw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .disable_n(disable_n_i), .zc(zc_pulse_i),
    .pwr_ok(pwr_ok), .expire(rel_expire), .brk_a(brk_a_en_o),
    .brk_b(brk_b_en_o), .rng_a(rng_a_en_o), .rng_b(rng_b_en_o)
);

// File: tb/tb_line_switch_ctrl.sv
module tb_line_switch_ctrl;
    localparam int unsigned RISE = 6;
    localparam int unsigned FALL = 3;
    localparam int unsigned TMO  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_sel = 1'b0, dis_n = 1'b1, frz = 1'b1, sup = 1'b0, zc = 1'b0;
    logic brk_a, brk_b, rng_a, rng_b;
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    line_switch_ctrl #(.SYNC_STAGES(2), .RISE_CNT(RISE), .FALL_CNT(FALL), .ZC_TMO(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .ring_sel_i(ring_sel), .disable_n_i(dis_n),
        .freeze_i(frz), .supply_ok_i(sup), .zc_pulse_i(zc),
        .brk_a_en_o(brk_a), .brk_b_en_o(brk_b), .rng_a_en_o(rng_a), .rng_b_en_o(rng_b)
    );

    // vector: {dis_n, ring_sel, zc, exp brk_a, brk_b, rng_a, rng_b}
    localparam logic [6:0] VEC [15] = '{
        7'b100_1100, 7'b110_0011, 7'b101_1101, 7'b100_1101, 7'b101_1100,
        7'b110_0011, 7'b010_0001, 7'b000_0001, 7'b001_0000, 7'b100_1100,
        7'b110_0011, 7'b111_0011, 7'b000_0001, 7'b110_0011, 7'b100_1101
    };

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {brk_a, brk_b, rng_a, rng_b};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state
        cycles(3);
        chk("R4 reset all open", 4'b0000);
        rst_n = 1'b1;

        // R6: power-up with freeze high stays in OFF
        sup = 1'b1;
        cycles(30);
        chk("R6 freeze high at power-up holds OFF", 4'b0000);
        frz = 1'b0;
        cycles(6);
        chk("R6 release to TALK (R1)", 4'b1100);

        // vector walk: R1 R2 R3 R8 R9 R11
        for (int i = 0; i < 15; i++) begin
            {dis_n, ring_sel, zc} = VEC[i][6:4];
            cycles(1);
            chk($sformatf("R1/R2/R3/R8/R9/R11 vector %0d", i), VEC[i][3:0]);
        end
        zc = 1'b0;

        // R10: timeout release of ringing switch B
        cycles(TMO - 1);
        chk("R10 before timeout", 4'b1101);
        cycles(1);
        chk("R10 timeout opens", 4'b1100);

        // R7: freeze after release
        frz = 1'b1;
        cycles(4);
        ring_sel = 1'b1;
        cycles(3);
        chk("R7 frozen command kept", 4'b1100);
        dis_n = 1'b0;
        cycles(1);
        chk("R3 disable while frozen", 4'b0000);
        dis_n = 1'b1;
        cycles(1);
        chk("R7 frozen command restored", 4'b1100);
        frz = 1'b0;
        cycles(4);
        chk("R7 unfreeze follows ring select (R2)", 4'b0011);
        ring_sel = 1'b0;
        cycles(TMO + 2);
        chk("R10 settle to TALK", 4'b1100);

        // R5: short low glitch ignored
        sup = 1'b0;
        cycles(FALL - 1);
        sup = 1'b1;
        for (int k = 0; k < 8; k++) begin
            cycles(1);
            chk("R5 short supply dip ignored", 4'b1100);
        end

        // R4: supply loss
        sup = 1'b0;
        cycles(FALL + 6);
        chk("R4 supply loss opens all", 4'b0000);
        ring_sel = 1'b1;
        cycles(3);
        chk("R4 inputs ignored without supply", 4'b0000);

        // R5: short high excursion ignored
        sup = 1'b1;
        cycles(RISE - 3);
        sup = 1'b0;
        cycles(10);
        chk("R5 short supply rise ignored", 4'b0000);

        // R6: power-up with freeze already low
        ring_sel = 1'b0;
        sup = 1'b1;
        cycles(RISE + 8);
        chk("R6 freeze low at power-up enters TALK", 4'b1100);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule